// File: doc/BRIEF.md
# Counter-Based Reference Clock Multiplier

This block builds a faster data clock from a slow reference input, using only flip-flops and adders that run on one fast system clock. It has no oscillator and no phase detector. The reference is first brought into the system clock domain, and its rising edges are found there. The block then counts how many system clock cycles lie between two edges. It splits that count into twice the programmed factor half-periods, toggles the output at those points, and starts the output over at every reference edge.

A phase accumulator in the style of a line-drawing algorithm adds twice the factor on every system cycle and takes away the measured period each time it crosses it. This places the left-over cycles evenly over the reference period, so every period holds exactly the programmed number of output cycles. Output edges can only fall on system clock edges, so the jitter is at most one system cycle. That jitter grows relative to the output period as the output frequency rises. The output should therefore stay at or below one-twentieth of the system clock rate, for example about 3.3 MHz from 66 MHz.

Top module: `digital_clk_mult`

## Requirements
- R1: `mul_sel` picks the factor F = 2^(mul_sel+1): 0 gives 2, 1 gives 4, and so on up to 7, which gives 256.
- R2: The reference passes through two synchronizing flops and then an edge detector. Once locked, `clk_out` goes high on the third rising system clock edge after `ref_in` is first sampled high, which realigns the output to the reference.
- R3: `locked` goes high on the realignment edge that follows the third reference rising edge after reset, that is, once two whole periods have been measured. After that it stays high.
- R4: `clk_out` stays low while `locked` is low.
- R5: After lock, each reference period holds exactly F rising edges of `clk_out`, provided the period is not shorter than the one measured before it. The output ends each period low.
- R6: Inside a reference period, every high and low phase of `clk_out` other than the final low lasts either floor(P/2F) or ceil(P/2F) system cycles. P is the previous period, counted in system cycles between reference rising edges.
- R7: A new `mul_sel` value is taken only at the next reference rising edge. A change in the middle of a period does not affect that period.
- R8: After reset, `clk_out` and `locked` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_in | input | 1 | Slow reference clock, asynchronous |
| mul_sel | input | 3 | Selects the factor, which is 2^(mul_sel+1) |
| clk_out | output | 1 | Synthesized clock, registered |
| locked | output | 1 | High once two periods have been measured |

## Verification
The assertions and the expected edge counts rely on three things about the inputs. Each reference period is at least 2F system cycles long, so the accumulator never has to toggle twice in one cycle. A period is never shorter than the one before it, so the final output cycle is never cut off. `mul_sel` does not change within a few cycles of a reference edge. The stimulus follows all three: it holds every period at 20F or more, it only ever lengthens the period, and it changes `mul_sel` only halfway through a period. The stimulus covers a period that does not divide evenly, a change of factor in the middle of a period, and a period that grows by a large step.

// File: rtl/clkmul_pkg.sv
package clkmul_pkg;
  localparam int SEL_W  = 3;
  localparam int STEP_W = 10;

  // number of output transitions per reference period (2F)
  function automatic logic [STEP_W-1:0] half_steps(input logic [SEL_W-1:0] s);
    return STEP_W'(4) << s;
  endfunction

  // factor F
  function automatic logic [STEP_W-1:0] factor_of(input logic [SEL_W-1:0] s);
    return STEP_W'(2) << s;
  endfunction
endpackage

// File: rtl/clkmul_sync.sv
module clkmul_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_in,
  output logic ref_rise
);
  logic [STAGES:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[STAGES-1:0], ref_in};
  end

  assign ref_rise = sync_q[STAGES-1] & ~sync_q[STAGES];
endmodule

// File: rtl/clkmul_meter.sv
module clkmul_meter
  import clkmul_pkg::*;
#(
  parameter int PER_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_rise,
  input  logic [SEL_W-1:0] mul_sel,
  output logic [PER_W-1:0] period_q,
  output logic [SEL_W-1:0] sel_q,
  output logic             locked,
  output logic             start
);
  logic [PER_W-1:0] cnt_q;
  logic [1:0]       seen_q;

  assign start = ref_rise & (locked | (seen_q == 2'd2));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      seen_q   <= '0;
      period_q <= '0;
      sel_q    <= '0;
      locked   <= 1'b0;
    end else if (ref_rise) begin
      cnt_q    <= PER_W'(1);
      period_q <= cnt_q;
      sel_q    <= mul_sel;
      if (seen_q != 2'd2) seen_q <= seen_q + 2'd1;
      if (start) locked <= 1'b1;
    end else if (cnt_q != '1) begin
      cnt_q <= cnt_q + PER_W'(1);
    end
  end
endmodule

// File: rtl/clkmul_toggle.sv
module clkmul_toggle
  import clkmul_pkg::*;
#(
  parameter int PER_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             locked,
  input  logic [PER_W-1:0] period_q,
  input  logic [SEL_W-1:0] sel_q,
  output logic             clk_out
);
  localparam int PW = PER_W + 1;

  logic [STEP_W-1:0] steps;
  logic [STEP_W-1:0] done_q;
  logic [PW-1:0]     acc_q;
  logic [PW-1:0]     acc_sum;
  logic [PW-1:0]     per_ext;

  assign steps   = half_steps(sel_q);
  assign acc_sum = acc_q + PW'(steps);
  assign per_ext = {1'b0, period_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_out <= 1'b0;
      acc_q   <= '0;
      done_q  <= '0;
    end else if (start) begin
      clk_out <= 1'b1;
      acc_q   <= '0;
      done_q  <= STEP_W'(1);
    end else if (!locked) begin
      clk_out <= 1'b0;
      acc_q   <= '0;
      done_q  <= '0;
    end else if (done_q < steps) begin
      if (acc_sum >= per_ext) begin
        clk_out <= ~clk_out;
        acc_q   <= acc_sum - per_ext;
        done_q  <= done_q + STEP_W'(1);
      end else begin
        acc_q <= acc_sum;
      end
    end
  end
endmodule

// File: rtl/digital_clk_mult.sv
module digital_clk_mult
  import clkmul_pkg::*;
#(
  parameter int PER_W  = 20,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_in,
  input  logic [SEL_W-1:0] mul_sel,
  output logic             clk_out,
  output logic             locked
);
  logic             ref_rise;
  logic             start;
  logic [PER_W-1:0] period_q;
  logic [SEL_W-1:0] sel_q;

  clkmul_sync #(.STAGES(STAGES)) u_sync (
    .clk(clk), .rst(rst), .ref_in(ref_in), .ref_rise(ref_rise)
  );

  clkmul_meter #(.PER_W(PER_W)) u_meter (
    .clk(clk), .rst(rst), .ref_rise(ref_rise), .mul_sel(mul_sel),
    .period_q(period_q), .sel_q(sel_q), .locked(locked), .start(start)
  );

  clkmul_toggle #(.PER_W(PER_W)) u_toggle (
    .clk(clk), .rst(rst), .start(start), .locked(locked),
    .period_q(period_q), .sel_q(sel_q), .clk_out(clk_out)
  );
endmodule

// File: rtl/digital_clk_mult_chk.sv
module digital_clk_mult_chk
  import clkmul_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             clk_out,
  input logic             locked,
  input logic             ref_rise,
  input logic [SEL_W-1:0] sel_q
);
  logic              out_d;
  logic [STEP_W-1:0] rcnt;
  logic [STEP_W-1:0] fac;

  assign fac = factor_of(sel_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_d <= 1'b0;
      rcnt  <= '0;
    end else begin
      out_d <= clk_out;
      if (ref_rise)              rcnt <= '0;
      else if (clk_out & ~out_d) rcnt <= rcnt + STEP_W'(1);
    end
  end

  assert_low_until_lock_R4: assert property (@(posedge clk) disable iff (rst)
    !locked |-> !clk_out);

  assert_lock_holds_R3: assert property (@(posedge clk) disable iff (rst)
    locked |=> locked);

  assert_realign_on_lock_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> clk_out);

  assert_sel_at_edge_R7: assert property (@(posedge clk) disable iff (rst)
    !ref_rise |=> $stable(sel_q));

  assert_rise_count_R5: assert property (@(posedge clk) disable iff (rst)
    rcnt <= fac);
endmodule

bind digital_clk_mult digital_clk_mult_chk u_chk (
  .clk(clk), .rst(rst), .clk_out(clk_out), .locked(locked),
  .ref_rise(ref_rise), .sel_q(sel_q)
);

// File: tb/digital_clk_mult_bench.sv
module digital_clk_mult_bench;
  localparam int CLK_HALF = 5;
  localparam int WATCHDOG = 200000;

  typedef struct {
    bit lock;
    int f;
    int p;
  } item_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ref_in = 1'b0;
  logic [2:0] mul_sel = 3'd0;
  logic       clk_out;
  logic       locked;

  int    errors = 0;
  int    checks = 0;
  bit    done = 1'b0;
  item_t exp_q[$];
  int    rise_n = 0;
  int    last_len = 0;

  digital_clk_mult u_digital_clk_mult (
    .clk(clk), .rst(rst), .ref_in(ref_in), .mul_sel(mul_sel),
    .clk_out(clk_out), .locked(locked)
  );

  always #CLK_HALF clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // driver: one reference period of len cycles; new_sel applied mid-period
  task automatic ref_pulse(input int len, input int new_sel);
    item_t it;
    rise_n++;
    it.lock = (rise_n >= 3);
    it.f    = 2 << mul_sel;                      // R1 factor encoding
    it.p    = last_len;
    exp_q.push_back(it);
    ref_in = 1'b1;
    repeat (len / 2) @(negedge clk);
    ref_in  = 1'b0;
    mul_sel = 3'(new_sel);                       // R7 mid-period change
    repeat (len - len / 2) @(negedge clk);
    last_len = len;
  endtask

  // monitor: samples one time unit after each rising edge
  initial begin
    bit    prev_out = 1'b0;
    bit    prev_ref = 1'b0;
    bit    d1 = 1'b0;
    bit    d2 = 1'b0;
    bit    have_cur = 1'b0;
    item_t cur;
    int    rises = 0;
    int    run_len = 0;
    forever begin
      @(posedge clk);
      #1;
      if (!rst) begin
        bit mark;
        bit close;
        mark  = ref_in & ~prev_ref;
        close = d2;
        d2 = d1;
        d1 = mark;
        run_len++;
        if (close) begin
          if (have_cur)
            check(rises == (cur.lock ? cur.f : 0), "R5 rises per period",
                  rises, cur.lock ? cur.f : 0);
          if (exp_q.size() == 0) begin
            check(1'b0, "R2 missing expected item", 0, 1);
          end else begin
            cur = exp_q.pop_front();
            have_cur = 1'b1;
            check(locked == cur.lock, "R3 locked at realign", int'(locked), int'(cur.lock));
            check(clk_out == cur.lock, "R2 R4 clk_out at realign", int'(clk_out), int'(cur.lock));
          end
          rises = clk_out ? 1 : 0;
          run_len = 0;
        end else if (clk_out != prev_out) begin
          if (clk_out) rises++;
          if (have_cur && cur.lock && cur.p > 0) begin
            int lo;
            int hi;
            lo = cur.p / (2 * cur.f);
            hi = (cur.p + 2 * cur.f - 1) / (2 * cur.f);
            check(run_len >= lo && run_len <= hi, "R6 phase length", run_len, lo);
          end else begin
            check(1'b0, "R4 output toggled while unlocked", int'(clk_out), 0);
          end
          run_len = 0;
        end
        prev_out = clk_out;
        prev_ref = ref_in;
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(clk_out == 1'b0, "R8 clk_out after reset", int'(clk_out), 0);
    check(locked == 1'b0, "R8 locked after reset", int'(locked), 0);
    repeat (10) @(negedge clk);
    // lock-up with F=2, three windows of 200 cycles
    ref_pulse(200, 0);
    check(locked == 1'b0, "R3 not locked after one edge", int'(locked), 0);
    ref_pulse(200, 0);
    check(locked == 1'b0, "R3 not locked after two edges", int'(locked), 0);
    ref_pulse(200, 0);
    ref_pulse(200, 1);                // R7: takes effect next period
    ref_pulse(203, 1);                // F=4, uneven period
    ref_pulse(203, 2);
    ref_pulse(203, 2);                // F=8 with remainder
    ref_pulse(400, 3);
    ref_pulse(400, 3);                // F=16
    ref_pulse(5200, 3);               // R5: lengthened period, still F
    ref_pulse(5200, 7);
    ref_pulse(5200, 7);               // F=256
    ref_pulse(5200, 6);
    ref_pulse(5200, 6);               // F=128
    repeat (10) @(negedge clk);
    check(locked == 1'b1, "R3 locked holds", int'(locked), 1);
    check(exp_q.size() == 0, "R2 all periods realigned", exp_q.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule